// File: doc/BRIEF.md
# Protection Context Entry Controller

This block holds the active protection context (PC) of a secure core and decides how that context may change. The PC is a 4-bit value; context 0 after reset grants full access, and the lowest contexts (as many as there are handler slots, `N_HND`) are privileged. Software may request a new PC through a register write. Such a request is honoured only if the target is outside the privileged range and its bit is set in the allowed-context mask.

The privileged contexts can be entered only by hardware. Each privileged context k has a handler-address register and a valid bit. When the core presents an instruction fetch whose address equals a valid handler address, the block makes k the active PC. Address bit 0 is ignored in this comparison. The PC that was active before the entry is kept in a saved-PC register. A rejected software request leaves the PC unchanged and raises a one-cycle error flag.

Configuration uses a small register port with eight word offsets. Writes are synchronous. Reads are combinational from the offset.

Top module: `pce_top`

## Requirements
- R1: After synchronous reset, the active PC and saved PC are 0, all handler registers and valid bits are 0, the error flag is low, and the allowed-context mask reads 0x0000FFFF.
- R2: A write to offset 6 with target t = wdata[3:0] is accepted when t >= N_HND and mask bit t is set. The active PC equals t from the clock edge that takes the write.
- R3: A software request to any target t < N_HND (this includes PC 0) is always rejected, whatever the current PC and the mask.
- R4: A software request whose target bit is clear in the mask (offset 5, bits 15:0, bit t for PC t) is rejected.
- R5: A rejected request leaves the active PC unchanged. sw_err is high for exactly the one cycle after the edge that took the request.
- R6: When fetch_vld is high, handler k (offset k, k < N_HND) has its valid bit set, and its address bits 31:1 equal fetch_addr[31:1], the active PC becomes k at that edge. Bit 0 of both addresses is ignored.
- R7: On each hardware entry, saved_pc takes the PC that was active before the entry. saved_pc changes at no other time.
- R8: A handler whose valid bit (offset 4, bit k for handler k) is clear never causes an entry, even on an exact address match.
- R9: When several valid handlers match the same fetch, the lowest-numbered context is entered.
- R10: When a hardware entry and a software request occur in the same cycle, the hardware entry takes effect. The request is discarded and sw_err is raised.
- R11: Reads return the following. Offsets 0..N_HND-1 give the handler addresses (unused slots read 0). Offset 4 gives the valid bits in bits 3:0. Offset 5 gives the mask. Offset 6 gives the active PC in bits 3:0. Offset 7 gives status, with saved PC in bits 7:4 and active PC in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from cfg_addr) |
| fetch_vld | input | 1 | Instruction fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch address |
| active_pc | output | 4 | Current protection context |
| saved_pc | output | 4 | Context active before the last hardware entry |
| sw_err | output | 1 | One-cycle flag for a rejected software request |

## Verification
Software requests are tried against several targets, each probing one rejection rule on its own:
- an allowed open context, which is accepted;
- PC 0 and another privileged context, which show the privileged range is protected independently of the mask;
- a context whose mask bit has been cleared, which shows the mask is enforced.

Fetches are tried in four forms, each separating one aspect of the handler comparison:
- an exact match on a handler that is not yet valid, which isolates the valid bit;
- a match that differs only in bit 0, which shows that bit is ignored;
- one address shared by two valid handlers, which exposes the priority order;
- an unrelated address, which shows that saved_pc holds.

A cycle that carries both a request and a matching fetch distinguishes hardware precedence from software precedence.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int PC_W    = 4;
    localparam int ADDR_W  = 32;
    localparam int MASK_W  = 1 << PC_W;
    localparam int OFS_W   = 3;
    localparam int MAX_HND = 4;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OFS_W-1:0] {
        OFS_HND0  = 3'd0,
        OFS_HND1  = 3'd1,
        OFS_HND2  = 3'd2,
        OFS_HND3  = 3'd3,
        OFS_VALID = 3'd4,
        OFS_MASK  = 3'd5,
        OFS_PCREQ = 3'd6,
        OFS_STAT  = 3'd7
    } ofs_e;

    typedef struct packed {
        logic vld;
        pc_t  target;
    } sw_req_t;

    typedef struct packed {
        logic hit;
        pc_t  idx;
    } hw_hit_t;

    // Handler comparison ignores the instruction-set bit (bit 0).
    function automatic logic handler_eq(addr_t a, addr_t b);
        return a[ADDR_W-1:1] == b[ADDR_W-1:1];
    endfunction

endpackage

// File: rtl/pce_cfg_regs.sv
module pce_cfg_regs
    import pce_pkg::*;
#(
    parameter int N_HND = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [OFS_W-1:0]       cfg_addr,
    input  addr_t                  cfg_wdata,
    output logic [N_HND-1:0][ADDR_W-1:0] hnd_addr,
    output logic [N_HND-1:0]       hnd_vld,
    output logic [MASK_W-1:0]      allow_mask,
    output sw_req_t                req
);

    localparam logic [MASK_W-1:0] MASK_RST = '1;

    ofs_e ofs;
    assign ofs = ofs_e'(cfg_addr);

    for (genvar k = 0; k < N_HND; k++) begin : g_hnd
        always_ff @(posedge clk) begin
            if (rst) begin
                hnd_addr[k] <= '0;
            end else if (cfg_we && (32'(cfg_addr) == k)) begin
                hnd_addr[k] <= cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hnd_vld    <= '0;
            allow_mask <= MASK_RST;
        end else if (cfg_we) begin
            if (ofs == OFS_VALID) hnd_vld    <= cfg_wdata[N_HND-1:0];
            if (ofs == OFS_MASK)  allow_mask <= cfg_wdata[MASK_W-1:0];
        end
    end

    always_comb begin
        req.vld    = cfg_we && (ofs == OFS_PCREQ);
        req.target = cfg_wdata[PC_W-1:0];
    end

endmodule

// File: rtl/pce_hnd_match.sv
module pce_hnd_match
    import pce_pkg::*;
#(
    parameter int N_HND = 4
) (
    input  logic                         fetch_vld,
    input  addr_t                        fetch_addr,
    input  logic [N_HND-1:0][ADDR_W-1:0] hnd_addr,
    input  logic [N_HND-1:0]             hnd_vld,
    output hw_hit_t                      hit
);

    logic [N_HND-1:0] eq;

    for (genvar k = 0; k < N_HND; k++) begin : g_cmp
        assign eq[k] = fetch_vld && hnd_vld[k] && handler_eq(hnd_addr[k], fetch_addr);
    end

    // Scan from the top down so the lowest matching index is left standing.
    always_comb begin
        hit = '0;
        for (int k = N_HND - 1; k >= 0; k--) begin
            if (eq[k]) begin
                hit.hit = 1'b1;
                hit.idx = PC_W'(k);
            end
        end
    end

endmodule

// File: rtl/pce_ctx_state.sv
module pce_ctx_state
    import pce_pkg::*;
#(
    parameter int N_HND = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  sw_req_t           req,
    input  hw_hit_t           hit,
    input  logic [MASK_W-1:0] allow_mask,
    output pc_t               active_pc,
    output pc_t               saved_pc,
    output logic              sw_err
);

    localparam pc_t FIRST_OPEN = PC_W'(N_HND);

    logic req_ok;
    assign req_ok = (req.target >= FIRST_OPEN) && allow_mask[req.target];

    always_ff @(posedge clk) begin
        if (rst) begin
            active_pc <= '0;
            saved_pc  <= '0;
            sw_err    <= 1'b0;
        end else begin
            sw_err <= 1'b0;
            if (hit.hit) begin
                saved_pc  <= active_pc;
                active_pc <= hit.idx;
                sw_err    <= req.vld;
            end else if (req.vld) begin
                if (req_ok) active_pc <= req.target;
                else        sw_err    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pce_top.sv
module pce_top
    import pce_pkg::*;
#(
    parameter int N_HND = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        fetch_vld,
    input  logic [31:0] fetch_addr,
    output logic [3:0]  active_pc,
    output logic [3:0]  saved_pc,
    output logic        sw_err
);

    logic [N_HND-1:0][ADDR_W-1:0] hnd_addr;
    logic [N_HND-1:0]             hnd_vld;
    logic [MASK_W-1:0]            allow_mask;
    sw_req_t                      req;
    hw_hit_t                      hit;

    pce_cfg_regs #(.N_HND(N_HND)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .hnd_addr   (hnd_addr),
        .hnd_vld    (hnd_vld),
        .allow_mask (allow_mask),
        .req        (req)
    );

    pce_hnd_match #(.N_HND(N_HND)) u_match (
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr),
        .hnd_addr   (hnd_addr),
        .hnd_vld    (hnd_vld),
        .hit        (hit)
    );

    pce_ctx_state #(.N_HND(N_HND)) u_state (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .hit        (hit),
        .allow_mask (allow_mask),
        .active_pc  (active_pc),
        .saved_pc   (saved_pc),
        .sw_err     (sw_err)
    );

    always_comb begin
        cfg_rdata = '0;
        case (ofs_e'(cfg_addr))
            OFS_VALID: cfg_rdata[N_HND-1:0]  = hnd_vld;
            OFS_MASK:  cfg_rdata[MASK_W-1:0] = allow_mask;
            OFS_PCREQ: cfg_rdata[PC_W-1:0]   = active_pc;
            OFS_STAT:  cfg_rdata[2*PC_W-1:0] = {saved_pc, active_pc};
            default: begin
                for (int k = 0; k < N_HND; k++) begin
                    if (32'(cfg_addr) == k) cfg_rdata = hnd_addr[k];
                end
            end
        endcase
    end

endmodule

// File: rtl/pce_checker.sv
module pce_checker #(
    parameter int N_HND = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [2:0] cfg_addr,
    input logic [3:0] req_pc,
    input logic       fetch_vld,
    input logic [3:0] active_pc,
    input logic [3:0] saved_pc,
    input logic       sw_err
);

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (active_pc == 4'd0 && saved_pc == 4'd0 && !sw_err));

    // R3: privileged contexts are only reached with a fetch in the prior cycle
    a_r3_no_sw_privileged: assert property (@(posedge clk) disable iff (rst)
        (active_pc != $past(active_pc) && 32'(active_pc) < N_HND) |-> $past(fetch_vld));

    // R2: a change without a fetch must be the requested target
    a_r2_sw_change_is_request: assert property (@(posedge clk) disable iff (rst)
        (active_pc != $past(active_pc) && !$past(fetch_vld)) |->
        ($past(cfg_we) && $past(cfg_addr) == 3'd6 && active_pc == $past(req_pc)));

    // R5: the error flag follows a request
    a_r5_err_cause: assert property (@(posedge clk) disable iff (rst)
        sw_err |-> ($past(cfg_we) && $past(cfg_addr) == 3'd6));

    // R5: a rejected request leaves the context alone
    a_r5_err_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (sw_err && !$past(fetch_vld)) |-> $stable(active_pc));

    // R7
    a_r7_saved_on_entry: assert property (@(posedge clk) disable iff (rst)
        (saved_pc != $past(saved_pc)) |-> ($past(fetch_vld) && saved_pc == $past(active_pc)));

endmodule

bind pce_top pce_checker #(.N_HND(N_HND)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .req_pc    (cfg_wdata[3:0]),
    .fetch_vld (fetch_vld),
    .active_pc (active_pc),
    .saved_pc  (saved_pc),
    .sw_err    (sw_err)
);

// File: tb/test_pce_top.sv
`timescale 1ns/1ps
module test_pce_top;

    localparam int N_HND = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        fetch_vld = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [3:0]  active_pc, saved_pc;
    logic        sw_err;

    always #4 clk = ~clk;

    pce_top #(.N_HND(N_HND)) i_pce_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fetch_vld(fetch_vld),
        .fetch_addr(fetch_addr), .active_pc(active_pc), .saved_pc(saved_pc),
        .sw_err(sw_err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_hnd [N_HND];
    logic [3:0]  m_vld;
    logic [15:0] m_mask;
    logic [3:0]  m_pc, m_sv;
    logic        m_err;

    always @(posedge clk) begin : model
        int hit;
        logic [3:0] t;
        if (rst) begin
            for (int k = 0; k < N_HND; k++) m_hnd[k] = '0;
            m_vld = '0; m_mask = 16'hFFFF; m_pc = '0; m_sv = '0; m_err = 1'b0;
        end else begin
            hit = -1;
            if (fetch_vld)
                for (int k = 0; k < N_HND; k++)
                    if (hit < 0 && m_vld[k] && m_hnd[k][31:1] == fetch_addr[31:1]) hit = k;
            m_err = 1'b0;
            t = cfg_wdata[3:0];
            if (hit >= 0) begin
                m_sv = m_pc;
                m_pc = 4'(hit);
                if (cfg_we && cfg_addr == 3'd6) m_err = 1'b1;
            end else if (cfg_we && cfg_addr == 3'd6) begin
                if (int'(t) >= N_HND && m_mask[t]) m_pc = t;
                else m_err = 1'b1;
            end
            if (cfg_we) begin
                if (int'(cfg_addr) < N_HND) m_hnd[cfg_addr[1:0]] = cfg_wdata;
                if (cfg_addr == 3'd4) m_vld = cfg_wdata[3:0];
                if (cfg_addr == 3'd5) m_mask = cfg_wdata[15:0];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R2 model active_pc", 32'(active_pc), 32'(m_pc));
            check("R7 model saved_pc", 32'(saved_pc), 32'(m_sv));
            check("R5 model sw_err", 32'(sw_err), 32'(m_err));
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic fetch(logic [31:0] a);
        @(negedge clk); fetch_vld = 1'b1; fetch_addr = a;
        @(negedge clk); fetch_vld = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
        cfg_addr = a; #1;
        check(tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 active_pc", 32'(active_pc), 0);
        check("R1 saved_pc", 32'(saved_pc), 0);
        check("R1 sw_err", 32'(sw_err), 0);
        rd(3'd5, 32'h0000FFFF, "R1 mask");
        rd(3'd4, 0, "R1 valid bits");
        rd(3'd0, 0, "R1 handler0");

        wr(3'd6, 5);
        check("R2 accept 5", 32'(active_pc), 5);
        wr(3'd6, 0);
        check("R3 reject 0", 32'(active_pc), 5);
        check("R5 err set", 32'(sw_err), 1);
        @(negedge clk);
        check("R5 err one cycle", 32'(sw_err), 0);
        wr(3'd6, 2);
        check("R3 reject 2", 32'(active_pc), 5);
        wr(3'd5, 32'h00F0);
        wr(3'd6, 9);
        check("R4 masked 9", 32'(active_pc), 5);
        check("R4 err", 32'(sw_err), 1);
        wr(3'd6, 6);
        check("R2 accept 6", 32'(active_pc), 6);

        wr(3'd0, 32'h0000_1001);
        fetch(32'h0000_1001);
        check("R8 invalid handler", 32'(active_pc), 6);
        wr(3'd4, 1);
        fetch(32'h0000_1000);
        check("R6 entry pc0", 32'(active_pc), 0);
        check("R7 saved 6", 32'(saved_pc), 6);
        wr(3'd6, 7);
        check("R2 accept 7 from pc0", 32'(active_pc), 7);

        wr(3'd2, 32'h0000_2000);
        wr(3'd1, 32'h0000_2001);
        wr(3'd4, 32'h7);
        fetch(32'h0000_2000);
        check("R9 lowest wins", 32'(active_pc), 1);
        check("R7 saved 7", 32'(saved_pc), 7);
        wr(3'd3, 32'h0000_3000);
        wr(3'd4, 32'hF);
        fetch(32'h0000_3001);
        check("R6 entry pc3", 32'(active_pc), 3);
        fetch(32'h0000_4000);
        check("R7 no entry keeps saved", 32'(saved_pc), 1);
        check("R6 no entry keeps pc", 32'(active_pc), 3);
        rd(3'd7, 32'h13, "R11 status");
        rd(3'd6, 32'h3, "R11 active read");
        rd(3'd2, 32'h2000, "R11 handler2");
        rd(3'd4, 32'hF, "R11 valid read");

        wr(3'd6, 4);
        check("R2 accept 4", 32'(active_pc), 4);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 32'd6;
        fetch_vld = 1'b1; fetch_addr = 32'h0000_2000;
        @(negedge clk);
        cfg_we = 1'b0; fetch_vld = 1'b0;
        check("R10 hw wins", 32'(active_pc), 1);
        check("R10 saved", 32'(saved_pc), 4);
        check("R10 err", 32'(sw_err), 1);

        wr(3'd4, 0);
        fetch(32'h0000_3000);
        check("R8 cleared valid", 32'(active_pc), 1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule